// File: doc/BRIEF.md
# Time-Gated Reciprocal Period and Duty Counter

This block measures a digital input over a whole number of that input's own cycles. Software arms it and gives it a minimum gate time in system clocks. The block first synchronizes the input. It opens a window on the next rising edge of the input. From then on it counts three things: system clocks elapsed, input cycles completed and clocks during which the input was high. Once the elapsed count has reached the gate time, the window closes on the next rising edge. All three counts are captured together on that edge, so the high-time and the period always describe the same cycles.

Software divides the captured numbers itself. Frequency is a constant times cycles over clocks, and duty is high clocks over clocks. The precision comes from the clock count, so it does not depend on the input frequency. Two operating modes exist. In continuous mode the closing edge also opens the next window, so no clock is lost between windows, and each capture overwrites the last one. In hold mode the first capture after arming is frozen until software reads it.

Top module: `recip_gate_counter`

## Requirements
- R1: The input passes through a two-flop synchronizer, and windows open and close only on rising edges of the synchronized signal. After arming, nothing is captured until a rising edge has opened a window.
- R2: For a steady periodic input with period P and high time H (in clocks) and gate time G, each window holds N = max(1, ceil(G/P)) cycles. It reports clkCount = N*P, highCount = N*H and cycCount = N.
- R3: A window closes on the first rising edge at which the elapsed clocks of the window are at least gateTime. A gateTime of 0 or 1 closes it on the very next rising edge.
- R4: done goes high on the clock after the closing edge is detected. In the same cycle the three result outputs show the new capture.
- R5: A cycle with readStrobe high clears done on the next clock, unless a capture happens in that same cycle.
- R6: With holdMode = 0 the closing edge opens the next window at once. Successive windows of a steady input therefore report identical counts, and measurement repeats without re-arming.
- R7: With holdMode = 1 the first capture after arming is held. Later input edges change neither the results nor done. After the read, no new capture occurs until the block is armed again.
- R8: Each count saturates at all ones instead of wrapping. Saturation of any count sets overflow, and overflow stays set.
- R9: After reset done and overflow are 0, all three result outputs are 0, and no window is open.
- R10: An arm pulse clears done and overflow and restarts the search for an opening edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sigIn | input | 1 | Asynchronous input being measured |
| gateTime | input | CNT_W | Minimum window length in system clocks |
| holdMode | input | 1 | 1: freeze the first capture after arming; 0: measure continuously |
| arm | input | 1 | One-cycle strobe that starts a new measurement |
| readStrobe | input | 1 | One-cycle strobe that acknowledges the results |
| clkCount | output | CNT_W | Captured system clocks in the window |
| cycCount | output | CNT_W | Captured completed input cycles |
| highCount | output | CNT_W | Captured clocks with the input high |
| done | output | 1 | A capture is waiting to be read |
| overflow | output | 1 | Sticky flag: a count saturated since the last arm |

## Verification
Several periodic waveforms are run in hold mode, each with its own period, high time and gate:
- A gate of zero and a gate of one must both give single-cycle windows.
- A gate equal to an exact multiple of the period tells the "at least" compare apart from a strict one.
- A gate one clock beyond that multiple must round the window up by a whole period.
- Long gates with narrow and wide pulses show that the high count and the clock count cover the same cycles.

In continuous mode, two windows in a row must agree exactly, which exposes any clock lost at the restart. A changed waveform after a held capture shows that later edges are ignored. A single long high pulse drives the counts into saturation.

// File: rtl/recip_gate_counter_pkg.sv
package recip_gate_counter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_RUN  = 2'd2,
    ST_HOLD = 2'd3
  } ctlState_t;

  // strobes from control to datapath, at most one of clear/open/step/close per cycle
  typedef struct packed {
    logic clear;     // zero everything (arm)
    logic open;      // first window starts on this edge
    logic step;      // accumulate one clock
    logic edgeSeen;  // with step: a rising edge inside the window
    logic close;     // capture results and restart on this edge
  } dpStrobe_t;

endpackage

// File: rtl/recip_gate_counter_edge.sv
module recip_gate_counter_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic sigLevel,
  output logic sigRise
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   levelPrev;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= sigIn;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) syncChain[g] <= 1'b0;
          else       syncChain[g] <= syncChain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) levelPrev <= 1'b0;
    else       levelPrev <= syncChain[SYNC_STAGES-1];
  end

  assign sigLevel = syncChain[SYNC_STAGES-1];
  assign sigRise  = syncChain[SYNC_STAGES-1] & ~levelPrev;

endmodule

// File: rtl/recip_gate_counter_satcnt.sv
module recip_gate_counter_satcnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         load,
  input  logic         loadBit,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         atMax
);

  localparam logic [W-1:0] MAX_VAL = '1;

  assign atMax = (value == MAX_VAL);

  always_ff @(posedge clk) begin
    if (!rstN || clear)    value <= '0;
    else if (load)         value <= W'(loadBit);
    else if (inc && !atMax) value <= value + W'(1);
  end

endmodule

// File: rtl/recip_gate_counter_datapath.sv
module recip_gate_counter_datapath
  import recip_gate_counter_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             sigLevel,
  input  logic [CNT_W-1:0] gateTime,
  output logic             gateFlag,
  output logic [CNT_W-1:0] resClk,
  output logic [CNT_W-1:0] resCyc,
  output logic [CNT_W-1:0] resHigh,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             restart;
  logic [CNT_W-1:0] accClk, accCyc, accHigh;
  logic             clkMax, cycMax, highMax;
  logic [CNT_W-1:0] clkNext, cycClosed;
  logic             satHit;

  assign restart = stb.open | stb.close;

  recip_gate_counter_satcnt #(.W(CNT_W)) clkCntI (
    .clk(clk), .rstN(rstN), .clear(stb.clear), .load(restart), .loadBit(1'b1),
    .inc(stb.step), .value(accClk), .atMax(clkMax));

  recip_gate_counter_satcnt #(.W(CNT_W)) highCntI (
    .clk(clk), .rstN(rstN), .clear(stb.clear), .load(restart), .loadBit(sigLevel),
    .inc(stb.step & sigLevel), .value(accHigh), .atMax(highMax));

  recip_gate_counter_satcnt #(.W(CNT_W)) cycCntI (
    .clk(clk), .rstN(rstN), .clear(stb.clear), .load(restart), .loadBit(1'b0),
    .inc(stb.step & stb.edgeSeen), .value(accCyc), .atMax(cycMax));

  // elapsed count the clock counter will hold after this edge
  assign clkNext   = clkMax ? accClk : accClk + ONE;
  // the closing edge completes one more cycle
  assign cycClosed = cycMax ? accCyc : accCyc + ONE;

  assign satHit = (stb.step  & (clkMax | (sigLevel & highMax) | (stb.edgeSeen & cycMax)))
                | (stb.close & cycMax);

  // gate-reached flag, one D flip-flop fed by the next elapsed value
  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) gateFlag <= 1'b0;
    else if (restart)       gateFlag <= (ONE >= gateTime);
    else if (stb.step)      gateFlag <= (clkNext >= gateTime);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resClk  <= '0;
      resCyc  <= '0;
      resHigh <= '0;
    end else if (stb.close) begin
      resClk  <= accClk;
      resCyc  <= cycClosed;
      resHigh <= accHigh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) ovf <= 1'b0;
    else if (satHit)        ovf <= 1'b1;
  end

endmodule

// File: rtl/recip_gate_counter_control.sv
module recip_gate_counter_control
  import recip_gate_counter_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      arm,
  input  logic      holdMode,
  input  logic      readStrobe,
  input  logic      sigRise,
  input  logic      gateFlag,
  output dpStrobe_t stb,
  output ctlState_t state,
  output logic      done
);

  ctlState_t nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    if (arm) begin
      stb.clear = 1'b1;
      nextState = ST_SEEK;
    end else begin
      unique case (state)
        ST_IDLE: nextState = ST_IDLE;
        ST_SEEK: begin
          if (sigRise) begin
            stb.open  = 1'b1;
            nextState = ST_RUN;
          end
        end
        ST_RUN: begin
          if (sigRise && gateFlag) begin
            stb.close = 1'b1;
            if (holdMode) nextState = ST_HOLD;
          end else begin
            stb.step     = 1'b1;
            stb.edgeSeen = sigRise;
          end
        end
        ST_HOLD: begin
          if (readStrobe) nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN || arm)    done <= 1'b0;
    else if (stb.close)  done <= 1'b1;
    else if (readStrobe) done <= 1'b0;
  end

endmodule

// File: rtl/recip_gate_counter.sv
module recip_gate_counter
  import recip_gate_counter_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sigIn,
  input  logic [CNT_W-1:0] gateTime,
  input  logic             holdMode,
  input  logic             arm,
  input  logic             readStrobe,
  output logic [CNT_W-1:0] clkCount,
  output logic [CNT_W-1:0] cycCount,
  output logic [CNT_W-1:0] highCount,
  output logic             done,
  output logic             overflow
);

  logic      sigLevel, sigRise, gateFlag;
  dpStrobe_t stb;
  ctlState_t state;

  recip_gate_counter_edge #(.SYNC_STAGES(SYNC_STAGES)) edgeI (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .sigLevel(sigLevel), .sigRise(sigRise));

  recip_gate_counter_control ctlI (
    .clk(clk), .rstN(rstN), .arm(arm), .holdMode(holdMode), .readStrobe(readStrobe),
    .sigRise(sigRise), .gateFlag(gateFlag), .stb(stb), .state(state), .done(done));

  recip_gate_counter_datapath #(.CNT_W(CNT_W)) dpI (
    .clk(clk), .rstN(rstN), .stb(stb), .sigLevel(sigLevel), .gateTime(gateTime),
    .gateFlag(gateFlag), .resClk(clkCount), .resCyc(cycCount), .resHigh(highCount),
    .ovf(overflow));

endmodule

// File: rtl/recip_gate_counter_chk.sv
module recip_gate_counter_chk
  import recip_gate_counter_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             arm,
  input logic             readStrobe,
  input logic [CNT_W-1:0] gateTime,
  input logic [CNT_W-1:0] clkCount,
  input logic [CNT_W-1:0] cycCount,
  input logic [CNT_W-1:0] highCount,
  input logic             done,
  input logic             overflow,
  input dpStrobe_t        stb,
  input ctlState_t        state
);

  a_r2_high_within_clk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (highCount <= clkCount));

  a_r2_cycles_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycCount != '0));

  a_r3_window_meets_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ((clkCount >= gateTime) || overflow));

  a_r4_close_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    stb.close |=> done);

  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !stb.close) |=> !done);

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && $past(state) == ST_HOLD)
      |-> ($stable(clkCount) && $stable(cycCount) && $stable(highCount) && done));

  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !arm) |=> overflow);

  a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!done && !overflow));

endmodule

bind recip_gate_counter recip_gate_counter_chk #(.CNT_W(CNT_W)) chkI (
  .clk(clk), .rstN(rstN), .arm(arm), .readStrobe(readStrobe), .gateTime(gateTime),
  .clkCount(clkCount), .cycCount(cycCount), .highCount(highCount), .done(done),
  .overflow(overflow), .stb(stb), .state(state));

// File: tb/recip_gate_counter_test.sv
module recip_gate_counter_test;

  localparam int W = 10;
  localparam int NVEC = 8;
  // period, high time, gate
  localparam int VEC [NVEC][3] = '{
    '{4, 2, 0}, '{4, 1, 1}, '{6, 3, 12}, '{6, 3, 13},
    '{10, 7, 25}, '{3, 1, 50}, '{2, 1, 9}, '{16, 15, 40}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sigIn = 1'b0;
  logic [W-1:0] gateTime = '0;
  logic         holdMode = 1'b1;
  logic         arm = 1'b0;
  logic         readStrobe = 1'b0;
  logic [W-1:0] clkCount, cycCount, highCount;
  logic         done, overflow;

  int nChecks = 0;
  int nErrors = 0;
  int wP = 0, wH = 0, wLevel = 0;
  int ph = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  recip_gate_counter #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .gateTime(gateTime), .holdMode(holdMode),
    .arm(arm), .readStrobe(readStrobe), .clkCount(clkCount), .cycCount(cycCount),
    .highCount(highCount), .done(done), .overflow(overflow));

  // waveform source, changes on falling edges
  always @(negedge clk) begin
    if (wP == 0) begin
      sigIn <= (wLevel != 0);
    end else begin
      if (ph >= wP) ph = 0;
      sigIn <= (ph < wH);
      ph = (ph + 1 >= wP) ? 0 : ph + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulseArm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " done seen"}, int'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErrors++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 done", int'(done), 0);
    check("R9 overflow", int'(overflow), 0);
    check("R9 clkCount", int'(clkCount), 0);
    check("R9 cycCount", int'(cycCount), 0);
    check("R9 highCount", int'(highCount), 0);

    // R1 no capture without a rising edge, even with a zero gate
    wP = 0; wLevel = 0; gateTime = '0;
    pulseArm();
    repeat (40) @(negedge clk);
    check("R1 no window before rising edge", int'(done), 0);

    // table walk in hold mode: R2 and R3
    for (int i = 0; i < NVEC; i++) begin
      int p = VEC[i][0];
      int h = VEC[i][1];
      int g = VEC[i][2];
      int n = (g + p - 1) / p;
      if (n < 1) n = 1;
      wP = p; wH = h;
      gateTime = W'(g);
      holdMode = 1'b1;
      pulseArm();
      waitDone("R4 table");
      check($sformatf("R2/R3 vec%0d clkCount", i), int'(clkCount), n * p);
      check($sformatf("R2 vec%0d highCount", i), int'(highCount), n * h);
      check($sformatf("R2/R3 vec%0d cycCount", i), int'(cycCount), n);
      pulseRead();
      check($sformatf("R5 vec%0d done cleared", i), int'(done), 0);
    end

    // R6 continuous mode: back-to-back windows agree
    wP = 7; wH = 3; gateTime = W'(20); holdMode = 1'b0;
    pulseArm();
    waitDone("R6 first");
    check("R6 first clkCount", int'(clkCount), 21);
    check("R6 first highCount", int'(highCount), 9);
    pulseRead();
    check("R5 continuous read clears", int'(done), 0);
    waitDone("R6 second");
    check("R6 second clkCount", int'(clkCount), 21);
    check("R6 second highCount", int'(highCount), 9);
    check("R6 second cycCount", int'(cycCount), 3);
    pulseRead();

    // R7 hold mode ignores later edges
    wP = 5; wH = 2; gateTime = W'(4); holdMode = 1'b1;
    pulseArm();
    waitDone("R7 capture");
    check("R7 clkCount", int'(clkCount), 5);
    wP = 9; wH = 4;
    repeat (60) @(negedge clk);
    check("R7 clkCount held", int'(clkCount), 5);
    check("R7 highCount held", int'(highCount), 2);
    check("R7 cycCount held", int'(cycCount), 1);
    check("R7 done held", int'(done), 1);
    pulseRead();
    repeat (60) @(negedge clk);
    check("R7 no capture after read until arm", int'(done), 0);
    check("R7 results kept after read", int'(clkCount), 5);

    // R8 saturation with one long high pulse
    wP = 0; wLevel = 0; gateTime = W'(100); holdMode = 1'b1;
    repeat (4) @(negedge clk);
    pulseArm();
    wLevel = 1;
    repeat (1100) @(negedge clk);
    check("R8 no close without edge", int'(done), 0);
    wLevel = 0;
    repeat (3) @(negedge clk);
    wLevel = 1;
    waitDone("R8 capture");
    check("R8 clkCount saturated", int'(clkCount), 1023);
    check("R8 highCount saturated", int'(highCount), 1023);
    check("R8 cycCount", int'(cycCount), 1);
    check("R8 overflow set", int'(overflow), 1);
    repeat (10) @(negedge clk);
    check("R8 overflow sticky", int'(overflow), 1);

    // R10 arm clears flags
    pulseArm();
    check("R10 done cleared", int'(done), 0);
    check("R10 overflow cleared", int'(overflow), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule